// File: doc/BRIEF.md
# Instruction Parcel Assembler with Length Decode

This block sits behind an instruction fetch path and accepts one 16-bit halfword per cycle over a valid/ready handshake. Each halfword can be byte-swapped on entry, which suits memories that store bytes big-endian. The swapped or unswapped value is the parcel. The block then builds complete instructions from these parcels. The first parcel of an instruction is enough to set its length: the decoder reads only that parcel's low bits, so the number of parcels still to come is known at once. Later parcels fill ever higher bit positions, whatever the byte order of the memory.

A finished instruction is presented at bit 0 of a 64-bit output word, together with its size in parcels and an illegal flag. It stays there until the consumer accepts it. No new parcels are taken while it waits. A synchronous flush drops any partial or waiting instruction, for example after a change of fetch address. A parameter limits the supported sizes to 16 and 32 bits. Under that limit, first parcels that encode longer instructions are reported as illegal single-parcel instructions.

Top module: `parcel_assembler`

## Requirements
- R1: During reset and in the first cycle after it, `out_valid_o` is 0 and `in_ready_o` is 1.
- R2: When `big_endian_i` is 1, each incoming halfword has its two bytes exchanged before use (raw 16'h3412 becomes parcel 16'h1234). When it is 0, the halfword is used unchanged.
- R3: The size in parcels comes from the first parcel p only. It is 1 when p[1:0] != 2'b11. It is 2 when p[1:0] == 2'b11 and p[4:2] != 3'b111. It is 3 when p[5:0] == 6'b011111. It is 4 when p[6:0] == 7'b0111111. `out_len_o` reports this size.
- R4: Parcel k of an instruction (k = 0 for the first) appears at `out_insn_o[16k+15:16k]`. All output bits above the instruction's size are 0.
- R5: A first parcel with p[6:0] == 7'b1111111, which includes 16'hFFFF, completes at once with `out_len_o` = 1 and `out_illegal_o` = 1.
- R6: An instruction whose bits are all zero is reported with `out_illegal_o` = 1. All other instructions of sizes 1 and 2 have `out_illegal_o` = 0.
- R7: With `ALLOW_LONG` = 0, a first parcel encoding size 3 or 4 completes at once with `out_len_o` = 1 and `out_illegal_o` = 1.
- R8: While `out_valid_o` is 1 and `out_ready_i` is 0, the output word, size and flag hold steady. During that time `in_ready_o` is 0, so offered parcels are not taken.
- R9: A cycle with `flush_i` = 1 discards the partial instruction, any waiting output, and any parcel offered in that same cycle. The next parcel accepted is treated as a first parcel.
- R10: `out_valid_o` rises in the cycle after the last parcel of an instruction is accepted. It falls in the cycle after a handshake with `out_ready_i` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| big_endian_i | input | 1 | Exchange the bytes of each incoming halfword |
| flush_i | input | 1 | Drop partial and waiting instructions |
| in_valid_i | input | 1 | Input halfword is valid |
| in_data_i | input | 16 | Raw halfword from memory |
| in_ready_o | output | 1 | Block takes the halfword this cycle |
| out_valid_o | output | 1 | A complete instruction is presented |
| out_ready_i | input | 1 | Consumer accepts the instruction |
| out_insn_o | output | 64 | Instruction at bit 0, upper bits zero |
| out_len_o | output | 3 | Instruction size in parcels (1 to 4) |
| out_illegal_o | output | 1 | Reserved or disabled encoding, or all-zero instruction |

## Verification
A wrong parcel count or stored size shows up at the ports as a wrong `out_len_o`. It also shifts the instruction boundaries, so every later instruction comes out misaligned until the next flush. A reference model therefore compares every output on every cycle, and an error is reported in the cycle it first appears. A wrong slot index shows as data in the wrong 16-bit field, or as nonzero upper bits, as soon as that instruction is presented. A stuck waiting-output state shows as `in_ready_o` staying low, or as parcels being taken that should have been held back. The first cycle in which the handshake differs from the model flags it.

// File: rtl/pa_pkg.sv
// Shared widths and types for the parcel assembler.
// Assumes parcels are 16 bits and at most four parcels form an instruction.
package pa_pkg;
    localparam int PARCEL_W    = 16;
    localparam int MAX_PARCELS = 4;
    localparam int INSN_W      = PARCEL_W * MAX_PARCELS;
    localparam int LEN_W       = $clog2(MAX_PARCELS + 1);

    typedef logic [PARCEL_W-1:0] parcel_t;

    // Size decision made from the first parcel.
    typedef struct packed {
        logic [LEN_W-1:0] parcels;
        logic             illegal;
    } len_info_t;
endpackage

// File: rtl/pa_byte_order.sv
// Byte-order stage: optionally reverses the bytes inside one halfword.
// Assumes the width is a whole number of bytes. The stage is purely combinational.
module pa_byte_order #(
    parameter int W = 16
) (
    input  logic [W-1:0] raw_i,
    input  logic         swap_i,
    output logic [W-1:0] parcel_o
);
    localparam int NB = W / 8;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        // Pick the mirrored byte when swapping.
        assign parcel_o[8*b +: 8] = swap_i ? raw_i[8*(NB-1-b) +: 8] : raw_i[8*b +: 8];
    end
endmodule

// File: rtl/pa_len_decode.sv
// Length decoder: sets the instruction size from the low bits of a first parcel.
// Assumes the parcel has already been put into instruction bit order.
// Sizes above two parcels are legal only when ALLOW_LONG is nonzero.
module pa_len_decode
    import pa_pkg::*;
#(
    parameter int ALLOW_LONG = 1
) (
    input  parcel_t   parcel_i,
    output len_info_t info_o
);
    logic long_ok;

    if (ALLOW_LONG != 0) begin : g_long
        assign long_ok = 1'b1;
    end else begin : g_short
        assign long_ok = 1'b0;
    end

    // Classify the low bits; a disabled or reserved size becomes one illegal parcel.
    always_comb begin
        info_o.parcels = LEN_W'(1);
        info_o.illegal = 1'b0;
        if (parcel_i[1:0] != 2'b11) begin
            info_o.parcels = LEN_W'(1);
        end else if (parcel_i[4:2] != 3'b111) begin
            info_o.parcels = LEN_W'(2);
        end else if (!parcel_i[5]) begin
            info_o.parcels = long_ok ? LEN_W'(3) : LEN_W'(1);
            info_o.illegal = !long_ok;
        end else if (!parcel_i[6]) begin
            info_o.parcels = long_ok ? LEN_W'(4) : LEN_W'(1);
            info_o.illegal = !long_ok;
        end else begin
            info_o.illegal = 1'b1;
        end
    end
endmodule

// File: rtl/pa_collector.sv
// Collector: places parcels into the instruction word and holds the result.
// Assumes the first-parcel size arrives combinationally with the parcel.
// Input ready is low whenever a finished instruction is waiting.
module pa_collector
    import pa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              in_valid_i,
    input  parcel_t           parcel_i,
    input  len_info_t         first_i,
    output logic              in_ready_o,
    output logic              out_valid_o,
    input  logic              out_ready_i,
    output logic [INSN_W-1:0] out_insn_o,
    output logic [LEN_W-1:0]  out_len_o,
    output logic              out_illegal_o
);
    logic              busy_q;
    logic [LEN_W-1:0]  cnt_q;
    logic [LEN_W-1:0]  need_q;
    logic [INSN_W-1:0] word_q;
    logic              ov_q;
    logic [LEN_W-1:0]  len_q;
    logic              ill_q;

    logic              take;
    logic [LEN_W-1:0]  slot;
    logic [LEN_W-1:0]  count_now;
    logic [LEN_W-1:0]  need_now;
    logic              ill_first;
    logic              done;
    logic [INSN_W-1:0] merged;

    assign in_ready_o = !ov_q;
    assign take       = in_valid_i && !ov_q && !flush_i;

    // Work out where the parcel goes and whether it finishes the instruction.
    always_comb begin
        slot      = busy_q ? cnt_q : '0;
        merged    = busy_q ? word_q : '0;
        merged[slot*PARCEL_W +: PARCEL_W] = parcel_i;
        count_now = slot + LEN_W'(1);
        need_now  = busy_q ? need_q : first_i.parcels;
        ill_first = !busy_q && first_i.illegal;
        done      = (count_now == need_now) || ill_first;
    end

    // Advance the collection state and the output holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            need_q <= '0;
            word_q <= '0;
            ov_q   <= 1'b0;
            len_q  <= '0;
            ill_q  <= 1'b0;
        end else if (flush_i) begin
            busy_q <= 1'b0;
            ov_q   <= 1'b0;
        end else begin
            if (ov_q && out_ready_i) begin
                ov_q <= 1'b0;
            end
            if (take) begin
                word_q <= merged;
                if (done) begin
                    busy_q <= 1'b0;
                    ov_q   <= 1'b1;
                    len_q  <= count_now;
                    ill_q  <= ill_first || (merged == '0);
                end else begin
                    busy_q <= 1'b1;
                    cnt_q  <= count_now;
                    need_q <= need_now;
                end
            end
        end
    end

    assign out_valid_o   = ov_q;
    assign out_insn_o    = word_q;
    assign out_len_o     = len_q;
    assign out_illegal_o = ill_q;
endmodule

// File: rtl/parcel_assembler.sv
// Top level: byte-order stage, first-parcel length decoder and collector.
// Assumes one halfword per cycle at most. Parcel order is always low bits first.
module parcel_assembler
    import pa_pkg::*;
#(
    parameter int ALLOW_LONG = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              big_endian_i,
    input  logic              flush_i,
    input  logic              in_valid_i,
    input  logic [15:0]       in_data_i,
    output logic              in_ready_o,
    output logic              out_valid_o,
    input  logic              out_ready_i,
    output logic [63:0]       out_insn_o,
    output logic [2:0]        out_len_o,
    output logic              out_illegal_o
);
    parcel_t   parcel;
    len_info_t first_info;

    pa_byte_order #(.W(PARCEL_W)) u_order (
        .raw_i    (in_data_i),
        .swap_i   (big_endian_i),
        .parcel_o (parcel)
    );

    pa_len_decode #(.ALLOW_LONG(ALLOW_LONG)) u_len (
        .parcel_i (parcel),
        .info_o   (first_info)
    );

    pa_collector u_coll (
        .clk           (clk),
        .rst_n         (rst_n),
        .flush_i       (flush_i),
        .in_valid_i    (in_valid_i),
        .parcel_i      (parcel),
        .first_i       (first_info),
        .in_ready_o    (in_ready_o),
        .out_valid_o   (out_valid_o),
        .out_ready_i   (out_ready_i),
        .out_insn_o    (out_insn_o),
        .out_len_o     (out_len_o),
        .out_illegal_o (out_illegal_o)
    );
endmodule

// File: rtl/pa_checker.sv
// Property checker for the parcel assembler, attached with bind.
// Assumes only the top-level ports are visible.
module pa_checker #(
    parameter int ALLOW_LONG = 1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        flush_i,
    input logic        in_ready_o,
    input logic        out_valid_o,
    input logic        out_ready_i,
    input logic [63:0] out_insn_o,
    input logic [2:0]  out_len_o,
    input logic        out_illegal_o
);
    localparam logic [2:0] MAX_LEN = (ALLOW_LONG != 0) ? 3'd4 : 3'd2;

    logic upper_clear;
    // Bits above the reported size must be zero.
    always_comb upper_clear = ((out_insn_o >> (32'(out_len_o) * 16)) == 64'd0);

    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i && !flush_i) |=>
        (out_valid_o && $stable(out_insn_o) && $stable(out_len_o) && $stable(out_illegal_o))); // R8
    AST_NO_TAKE_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> !in_ready_o); // R8
    AST_LEN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (out_len_o >= 3'd1 && out_len_o <= MAX_LEN)); // R7
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> upper_clear); // R4
    AST_ZERO_IS_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_insn_o == 64'd0) |-> out_illegal_o); // R6
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !out_valid_o); // R9
    AST_RETIRE_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_ready_i) |=> !out_valid_o); // R10
endmodule

bind parcel_assembler pa_checker #(.ALLOW_LONG(ALLOW_LONG)) u_pa_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush_i       (flush_i),
    .in_ready_o    (in_ready_o),
    .out_valid_o   (out_valid_o),
    .out_ready_i   (out_ready_i),
    .out_insn_o    (out_insn_o),
    .out_len_o     (out_len_o),
    .out_illegal_o (out_illegal_o)
);

// File: tb/parcel_assembler_tb_top.sv
// Bench: directed cases, then a random stream compared each cycle with a behavioural model.
module parcel_assembler_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        big = 1'b0;
    logic        flush = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        out_ready = 1'b0;

    logic        in_ready, out_valid, out_ill;
    logic [63:0] out_insn;
    logic [2:0]  out_len;
    logic        s_in_ready, s_out_valid, s_out_ill;
    logic [63:0] s_out_insn;
    logic [2:0]  s_out_len;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    parcel_assembler #(.ALLOW_LONG(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .big_endian_i(big), .flush_i(flush),
        .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
        .out_valid_o(out_valid), .out_ready_i(out_ready), .out_insn_o(out_insn),
        .out_len_o(out_len), .out_illegal_o(out_ill)
    );

    parcel_assembler #(.ALLOW_LONG(0)) dut_short_i (
        .clk(clk), .rst_n(rst_n), .big_endian_i(big), .flush_i(flush),
        .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(s_in_ready),
        .out_valid_o(s_out_valid), .out_ready_i(out_ready), .out_insn_o(s_out_insn),
        .out_len_o(s_out_len), .out_illegal_o(s_out_ill)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model of the length rules.
    function automatic void size_of(input logic [15:0] p, input bit allow, output int n, output bit bad);
        bad = 0;
        case (1'b1)
            (p[1:0] != 2'b11):          n = 1;
            (p[4:2] != 3'b111):         n = 2;
            (p[6:0] == 7'b1111111):     begin n = 1; bad = 1; end
            default: begin
                n = (p[5] == 1'b0) ? 3 : 4;
                if (!allow) begin n = 1; bad = 1; end
            end
        endcase
    endfunction

    logic [15:0] m_q[$];
    int          m_need;
    bit          m_bad;
    bit          m_ov;
    logic [63:0] m_insn;
    int          m_len;
    bit          m_ill;

    // Model state update at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_q.delete(); m_ov = 0; m_insn = '0; m_len = 0; m_ill = 0;
        end else if (flush) begin
            m_q.delete(); m_ov = 0;
        end else if (m_ov) begin
            if (out_ready) m_ov = 0;
        end else if (in_valid) begin
            logic [15:0] p;
            p = big ? {in_data[7:0], in_data[15:8]} : in_data;
            m_q.push_back(p);
            if (m_q.size() == 1) size_of(p, 1'b1, m_need, m_bad);
            if (m_q.size() == m_need) begin
                m_insn = '0;
                foreach (m_q[k]) m_insn[16*k +: 16] = m_q[k];
                m_len = m_need;
                m_ill = m_bad || (m_insn == '0);
                m_ov  = 1;
                m_q.delete();
            end
        end
    end

    // Every-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(in_ready == !m_ov, "R8 in_ready", 64'(in_ready), 64'(!m_ov));
            chk(out_valid == m_ov, "R10 out_valid", 64'(out_valid), 64'(m_ov));
            if (m_ov) begin
                chk(out_insn == m_insn, "R4 insn", out_insn, m_insn);
                chk(out_len == 3'(m_len), "R3 len", 64'(out_len), 64'(m_len));
                chk(out_ill == m_ill, "R5 illegal", 64'(out_ill), 64'(m_ill));
            end
        end
    end

    task automatic put(input logic [15:0] d);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_data = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_out(input logic [63:0] insn, input int len, input bit ill, input string tag);
        chk(out_valid == 1'b1, {tag, " valid"}, 64'(out_valid), 64'd1);
        chk(out_insn == insn, {tag, " insn"}, out_insn, insn);
        chk(out_len == 3'(len), {tag, " len"}, 64'(out_len), 64'(len));
        chk(out_ill == ill, {tag, " illegal"}, 64'(out_ill), 64'(ill));
    endtask

    task automatic retire();
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk(out_valid == 1'b0, "R10 drop after accept", 64'(out_valid), 64'd0);
    endtask

    task automatic pulse_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 in reset", {62'd0, out_valid, in_ready}, 64'b01);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 after reset", {62'd0, out_valid, in_ready}, 64'b01);

        // R7: long encoding on the short-only instance.
        put(16'h001F);
        chk(s_out_valid && s_out_len == 3'd1 && s_out_ill, "R7 short build 48-bit",
            {59'd0, s_out_valid, s_out_len, s_out_ill}, {59'd0, 1'b1, 3'd1, 1'b1});
        chk(out_valid == 1'b0, "R3 48-bit still collecting", 64'(out_valid), 64'd0);
        pulse_flush();

        put(16'h1234);
        expect_out(64'h1234, 1, 0, "R3 R10 16-bit");
        retire();

        big = 1'b1;
        put(16'h3412);
        expect_out(64'h1234, 1, 0, "R2 swapped");
        retire();
        big = 1'b0;

        put(16'h1063); put(16'hABCD);
        expect_out(64'hABCD_1063, 2, 0, "R4 32-bit");
        // R8: stall with a parcel offered.
        in_valid = 1'b1; in_data = 16'h5555;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(in_ready == 1'b0, "R8 ready low", 64'(in_ready), 64'd0);
            chk(out_insn == 64'hABCD_1063, "R8 hold", out_insn, 64'hABCD_1063);
        end
        in_valid = 1'b0;
        retire();

        put(16'h001F); put(16'h1111); put(16'h2222);
        expect_out(64'h2222_1111_001F, 3, 0, "R3 48-bit");
        retire();

        put(16'h003F); put(16'hAAAA); put(16'hBBBB); put(16'hCCCC);
        expect_out(64'hCCCC_BBBB_AAAA_003F, 4, 0, "R4 64-bit");
        retire();

        put(16'h007F);
        expect_out(64'h007F, 1, 1, "R5 reserved");
        retire();
        put(16'hFFFF);
        expect_out(64'hFFFF, 1, 1, "R5 all ones");
        retire();

        put(16'h0000);
        expect_out(64'h0, 1, 1, "R6 all zero");
        retire();

        // R9: partial instruction then flush, with a parcel offered during the flush.
        put(16'h0003);
        flush = 1'b1; in_valid = 1'b1; in_data = 16'h0013;
        @(negedge clk);
        flush = 1'b0; in_valid = 1'b0;
        chk(out_valid == 1'b0, "R9 flushed", 64'(out_valid), 64'd0);
        put(16'h0ABC);
        expect_out(64'h0ABC, 1, 0, "R9 fresh start");
        retire();

        // Random stream checked against the model.
        for (int c = 0; c < 20000; c++) begin
            logic [15:0] r;
            r = 16'($urandom);
            case ($urandom % 10)
                0: in_data = 16'h0000;
                1: in_data = {r[15:6], 6'b011111};
                2: in_data = {r[15:7], 7'b0111111};
                3: in_data = 16'hFFFF;
                4: in_data = {r[15:7], 7'b1111111};
                default: in_data = r;
            endcase
            if (big) in_data = {in_data[7:0], in_data[15:8]};
            in_valid  = ($urandom % 4) != 0;
            out_ready = ($urandom % 3) != 0;
            flush     = ($urandom % 60) == 0;
            if (($urandom % 500) == 0) big = !big;
            @(negedge clk);
        end
        in_valid = 1'b0; flush = 1'b0; out_ready = 1'b0;

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule